// File: doc/BRIEF.md
# Timer Channel Compare Output Stage

This block is one timer channel used as an output. A free-running up/down counter runs from zero to a programmable period value. Each clock, its value is compared with a channel data value. An eight-way mode field picks how the compare result shapes a registered raw waveform:

- hold the current level
- set, clear or toggle on a match
- force low or force high
- one of two pulse-width modulation shapes

The period value sets the output period and the data value sets the duty.

Two options modify the timing. A one-pulse option makes the counter stop by itself at the end of the period it is running, so only one pulse comes out. A fast option evaluates the compare against the value the counter is about to take, so a level change lands together with the counter value that causes it. This also means a new period starts with its level already in place.

The raw waveform leaves the block unpolarized, for use as a trigger by a neighbouring controller. A polarity bit and an enable then turn it into the pin drive. A one-cycle compare flag marks each match in every mode.

Top module: `tmr_chan_out`

## Requirements
- R1: While reset is asserted and just after it, the outputs read as follows: counter value 0, counter running 0, raw output 0, compare flag 0.
- R2: The counter changes only while running, by one step per clock. When counting up (dirDown=0) it goes from period to 0. When counting down (dirDown=1) it goes from 0 to period. When not running it keeps its value.
- R3: A high enSet makes the counter run from the next clock. A high enClr stops it from the next clock, and enClr wins when both are high. The running state is visible on cntRun.
- R4: Mode 3'b110 sets the raw output one clock after the counter shows a value V. Counting up, the output is high when data > V. Counting down, it is high when data >= V. Otherwise it is low.
- R5: Mode 3'b111 gives the inverse of the mode 3'b110 level in both directions, with the same timing.
- R6: Mode 3'b100 drives the raw output low and mode 3'b101 drives it high on every clock, whatever the counter holds. Mode 3'b000 keeps the raw output at its present level.
- R7: A match is a clock on which the counter runs and equals the data value. On a match, mode 3'b001 sets the raw output high, mode 3'b010 sets it low, and mode 3'b011 inverts it. The change is visible one clock later.
- R8: The compare flag is high for the one clock that follows each clock on which the counter runs and equals the data value. This holds in every mode, including the forced ones.
- R9: With onePulse high, the clock that wraps or reloads the counter also clears the running state. The counter then holds its wrapped or reloaded value.
- R10: With fastOut high, the modes of R4, R5 and R7 use the value the counter takes on that clock in place of its present value. The raw level then lines up with the counter value that produced it.
- R11: While chSel is 2'b00 the channel is not an output. The raw output keeps its level and the pin sits at the level of polarity.
- R12: With chEnable high and chSel nonzero, the pin is the raw output XOR polarity. Otherwise the pin is the polarity level. The raw output does not depend on polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enSet | input | 1 | Start counting |
| enClr | input | 1 | Stop counting (wins over enSet) |
| dirDown | input | 1 | 1 counts down, 0 counts up |
| onePulse | input | 1 | Stop at end of current period |
| fastOut | input | 1 | Compare against the counter's next value |
| period | input | CNT_W | Period (top count) value |
| chData | input | CNT_W | Channel compare value |
| outMode | input | 3 | Output mode code |
| chSel | input | 2 | Channel select, nonzero means output |
| polarity | input | 1 | Inverts the pin, also the idle pin level |
| chEnable | input | 1 | Pin enable |
| cntVal | output | CNT_W | Counter value |
| cntRun | output | 1 | Counter running |
| rawOut | output | 1 | Unpolarized compare waveform (trigger output) |
| cmpFlag | output | 1 | One-clock match pulse |
| pinOut | output | 1 | Polarized, gated pin drive |

## Verification
A counter that steps wrongly at a wrap or reload shows on cntVal on the very next clock. It then shifts every later compare flag and raw edge too, so a single bad boundary spoils the rest of the period at the ports. A raw-output register that took the wrong compare operand, direction or mode action differs from the expected level one clock after the counter value that should have set it. A run flag that misses its one-pulse or clear condition shows up on cntRun and a moving cntVal within one clock of the period end. Checking every output on every clock against an independent model catches each of these within a single cycle.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [2:0] {
    OM_HOLD = 3'b000,
    OM_SET  = 3'b001,
    OM_CLR  = 3'b010,
    OM_TGL  = 3'b011,
    OM_LOW  = 3'b100,
    OM_HIGH = 3'b101,
    OM_PWMA = 3'b110,
    OM_PWMB = 3'b111
  } outMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;      // counter advances this clock
    logic down;      // count direction
    logic chActive;  // channel configured as output
  } ctlStrobe_t;

endpackage

// File: rtl/tmr_chan_ctl.sv
module tmr_chan_ctl
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enSet,
  input  logic       enClr,
  input  logic       dirDown,
  input  logic       onePulse,
  input  logic [1:0] chSel,
  input  logic       atLimit,
  output ctlStrobe_t strobe,
  output logic       run
);

  logic periodEnd;
  logic runNext;

  always_comb begin
    periodEnd = run && atLimit;
    runNext   = run;
    if (enClr || (onePulse && periodEnd)) runNext = 1'b0;
    else if (enSet)                       runNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= runNext;
  end

  always_comb begin
    strobe.step     = run;
    strobe.down     = dirDown;
    strobe.chActive = |chSel;
  end

  assert_one_pulse_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && onePulse && atLimit) |=> !run);

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enClr |=> !run);

endmodule

// File: rtl/tmr_chan_dp.sv
module tmr_chan_dp
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       strobe,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] chData,
  input  outMode_e         outMode,
  input  logic             fastOut,
  input  logic             polarity,
  input  logic             chEnable,
  output logic [CNT_W-1:0] cntVal,
  output logic             atLimit,
  output logic             rawOut,
  output logic             cmpFlag,
  output logic             pinOut
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] evalCnt;
  logic             matchHit;
  logic             pwmLevel;
  logic             rawNext;

  // Counter
  always_comb begin
    atLimit = strobe.down ? (cntVal == CNT_ZERO) : (cntVal == period);
    cntNext = cntVal;
    if (strobe.step) begin
      if (atLimit)          cntNext = strobe.down ? period : CNT_ZERO;
      else if (strobe.down) cntNext = cntVal - CNT_ONE;
      else                  cntNext = cntVal + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cntVal <= CNT_ZERO;
    else        cntVal <= cntNext;
  end

  // Compare and mode decode
  always_comb begin
    evalCnt  = fastOut ? cntNext : cntVal;
    matchHit = strobe.step && (evalCnt == chData);
    pwmLevel = strobe.down ? (chData >= evalCnt) : (chData > evalCnt);
    case (outMode)
      OM_SET:  rawNext = matchHit ? 1'b1 : rawOut;
      OM_CLR:  rawNext = matchHit ? 1'b0 : rawOut;
      OM_TGL:  rawNext = matchHit ? ~rawOut : rawOut;
      OM_LOW:  rawNext = 1'b0;
      OM_HIGH: rawNext = 1'b1;
      OM_PWMA: rawNext = pwmLevel;
      OM_PWMB: rawNext = ~pwmLevel;
      default: rawNext = rawOut;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rawOut  <= 1'b0;
      cmpFlag <= 1'b0;
    end else begin
      if (strobe.chActive) rawOut <= rawNext;
      cmpFlag <= strobe.step && (cntVal == chData);
    end
  end

  // Output stage
  always_comb begin
    if (chEnable && strobe.chActive) pinOut = rawOut ^ polarity;
    else                             pinOut = polarity;
  end

  assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && !strobe.down && cntVal == period) |=> (cntVal == CNT_ZERO));

  assert_down_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.step && strobe.down && cntVal == CNT_ZERO) |=> (cntVal == $past(period)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.step |=> $stable(cntVal));

  assert_force_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.chActive && outMode == OM_LOW) |=> !rawOut);

  assert_force_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.chActive && outMode == OM_HIGH) |=> rawOut);

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.chActive && outMode == OM_TGL && !fastOut && strobe.step && cntVal == chData)
      |=> (rawOut != $past(rawOut)));

  assert_sel_off_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.chActive |=> $stable(rawOut));

endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enSet,
  input  logic             enClr,
  input  logic             dirDown,
  input  logic             onePulse,
  input  logic             fastOut,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] chData,
  input  logic [2:0]       outMode,
  input  logic [1:0]       chSel,
  input  logic             polarity,
  input  logic             chEnable,
  output logic [CNT_W-1:0] cntVal,
  output logic             cntRun,
  output logic             rawOut,
  output logic             cmpFlag,
  output logic             pinOut
);

  ctlStrobe_t strobe;
  logic       atLimit;

  tmr_chan_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enSet    (enSet),
    .enClr    (enClr),
    .dirDown  (dirDown),
    .onePulse (onePulse),
    .chSel    (chSel),
    .atLimit  (atLimit),
    .strobe   (strobe),
    .run      (cntRun)
  );

  tmr_chan_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .period   (period),
    .chData   (chData),
    .outMode  (outMode_e'(outMode)),
    .fastOut  (fastOut),
    .polarity (polarity),
    .chEnable (chEnable),
    .cntVal   (cntVal),
    .atLimit  (atLimit),
    .rawOut   (rawOut),
    .cmpFlag  (cmpFlag),
    .pinOut   (pinOut)
  );

endmodule

// File: tb/tmr_chan_out_tb.sv
module tmr_chan_out_tb;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enSet = 1'b0, enClr = 1'b0, dirDown = 1'b0, onePulse = 1'b0, fastOut = 1'b0;
  logic [CNT_W-1:0] period = '0, chData = '0;
  logic [2:0]       outMode = 3'b000;
  logic [1:0]       chSel = 2'b00;
  logic             polarity = 1'b0, chEnable = 1'b0;
  logic [CNT_W-1:0] cntVal;
  logic             cntRun, rawOut, cmpFlag, pinOut;

  int nChecks = 0;
  int nBad = 0;

  // Reference model state
  int mCnt = 0;
  bit mRun = 0, mRaw = 0, mFlag = 0;

  always #4 clk = ~clk;

  tmr_chan_out #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enSet(enSet), .enClr(enClr), .dirDown(dirDown),
    .onePulse(onePulse), .fastOut(fastOut), .period(period), .chData(chData),
    .outMode(outMode), .chSel(chSel), .polarity(polarity), .chEnable(chEnable),
    .cntVal(cntVal), .cntRun(cntRun), .rawOut(rawOut), .cmpFlag(cmpFlag), .pinOut(pinOut)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic       down;
    logic       fast;
    logic       op;
    logic [7:0] per;
    logic [7:0] dat;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{3'b110, 1'b0, 1'b0, 1'b0, 8'd5, 8'd2},
    '{3'b110, 1'b1, 1'b0, 1'b0, 8'd5, 8'd2},
    '{3'b111, 1'b0, 1'b0, 1'b0, 8'd4, 8'd3},
    '{3'b111, 1'b1, 1'b0, 1'b0, 8'd4, 8'd0},
    '{3'b001, 1'b0, 1'b0, 1'b0, 8'd3, 8'd2},
    '{3'b010, 1'b1, 1'b0, 1'b0, 8'd3, 8'd1},
    '{3'b011, 1'b0, 1'b0, 1'b0, 8'd3, 8'd3},
    '{3'b101, 1'b0, 1'b0, 1'b0, 8'd3, 8'd1},
    '{3'b110, 1'b0, 1'b1, 1'b0, 8'd5, 8'd2},
    '{3'b011, 1'b1, 1'b1, 1'b0, 8'd4, 8'd2},
    '{3'b110, 1'b0, 1'b0, 1'b1, 8'd5, 8'd3},
    '{3'b000, 1'b0, 1'b0, 1'b0, 8'd3, 8'd1},
    '{3'b100, 1'b1, 1'b0, 1'b0, 8'd3, 8'd2}
  };

  function automatic string rowTag(input logic [2:0] mode, input logic fast, input logic op);
    if (op)                   return "R9";
    if (fast)                 return "R10";
    if (mode == 3'b110)       return "R4";
    if (mode == 3'b111)       return "R5";
    if (mode inside {3'b001, 3'b010, 3'b011}) return "R7";
    return "R6";
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock: advance the model from requirements, then compare every output
  task automatic cycle(input string rawTag);
    bit lim, hit, pwm, nRun, nRaw, nFlag;
    int nCnt, ev;
    lim  = dirDown ? (mCnt == 0) : (mCnt == int'(period));
    nCnt = mCnt;
    if (mRun) nCnt = lim ? (dirDown ? int'(period) : 0) : (dirDown ? mCnt - 1 : mCnt + 1);
    ev   = fastOut ? nCnt : mCnt;
    hit  = mRun && (ev == int'(chData));
    pwm  = dirDown ? (int'(chData) >= ev) : (int'(chData) > ev);
    case (outMode)
      3'b001:  nRaw = hit ? 1'b1 : mRaw;
      3'b010:  nRaw = hit ? 1'b0 : mRaw;
      3'b011:  nRaw = hit ? ~mRaw : mRaw;
      3'b100:  nRaw = 1'b0;
      3'b101:  nRaw = 1'b1;
      3'b110:  nRaw = pwm;
      3'b111:  nRaw = ~pwm;
      default: nRaw = mRaw;
    endcase
    if (chSel == 2'b00) nRaw = mRaw;
    nFlag = mRun && (mCnt == int'(chData));
    nRun  = mRun;
    if (enClr || (onePulse && mRun && lim)) nRun = 1'b0;
    else if (enSet)                         nRun = 1'b1;
    @(posedge clk);
    #2;
    mCnt = nCnt; mRun = nRun; mRaw = nRaw; mFlag = nFlag;
    chk("R2", int'(cntVal), mCnt, "cntVal");
    chk("R3", int'(cntRun), int'(mRun), "cntRun");
    chk(rawTag, int'(rawOut), int'(mRaw), "rawOut");
    chk("R8", int'(cmpFlag), int'(mFlag), "cmpFlag");
    chk("R12", int'(pinOut),
        int'((chEnable && chSel != 2'b00) ? (mRaw ^ polarity) : polarity), "pinOut");
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    mCnt = 0; mRun = 0; mRaw = 0; mFlag = 0;
    rst_n = 1'b1;
  endtask

  task automatic startRun(input string tag);
    enSet = 1'b1;
    cycle(tag);
    enSet = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    // R1: reset state
    @(posedge clk);
    #2;
    chk("R1", int'(cntVal), 0, "cntVal in reset");
    chk("R1", int'(cntRun), 0, "cntRun in reset");
    chk("R1", int'(rawOut), 0, "rawOut in reset");
    chk("R1", int'(cmpFlag), 0, "cmpFlag in reset");
    doReset();

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      doReset();
      outMode  = VECS[i].mode;
      dirDown  = VECS[i].down;
      fastOut  = VECS[i].fast;
      onePulse = VECS[i].op;
      period   = CNT_W'(VECS[i].per);
      chData   = CNT_W'(VECS[i].dat);
      chSel    = 2'b01;
      chEnable = 1'b1;
      polarity = i[0];
      startRun(rowTag(VECS[i].mode, VECS[i].fast, VECS[i].op));
      for (int c = 0; c < 16; c++) cycle(rowTag(VECS[i].mode, VECS[i].fast, VECS[i].op));
    end

    // R9: after a one-pulse run the counter has stopped at its wrapped value
    doReset();
    outMode = 3'b110; dirDown = 1'b0; fastOut = 1'b0; onePulse = 1'b1;
    period = 16'd3; chData = 16'd2; chSel = 2'b01; chEnable = 1'b1; polarity = 1'b0;
    startRun("R9");
    for (int c = 0; c < 8; c++) cycle("R9");
    chk("R9", int'(cntRun), 0, "one-pulse stopped");
    chk("R9", int'(cntVal), 0, "one-pulse final count");
    onePulse = 1'b0;

    // R3: clear wins over set, counter then holds
    doReset();
    period = 16'd7; startRun("R4");
    cycle("R4"); cycle("R4"); cycle("R4");
    enSet = 1'b1; enClr = 1'b1;
    cycle("R3");
    enSet = 1'b0; enClr = 1'b0;
    chk("R3", int'(cntRun), 0, "clear beats set");
    chk("R2", int'(cntVal), 4, "count at stop");
    cycle("R2"); cycle("R2");
    chk("R2", int'(cntVal), 4, "count held while stopped");

    // R6: forced high then forced low, flag still follows matches (R8)
    doReset();
    period = 16'd3; chData = 16'd1; outMode = 3'b101;
    startRun("R6");
    for (int c = 0; c < 5; c++) cycle("R6");
    outMode = 3'b100;
    for (int c = 0; c < 5; c++) cycle("R6");
    outMode = 3'b000;
    for (int c = 0; c < 4; c++) cycle("R6");

    // R11: channel not an output, raw holds, pin at polarity
    outMode = 3'b101; cycle("R6");
    chk("R6", int'(rawOut), 1, "forced high before deselect");
    chSel = 2'b00; outMode = 3'b100; polarity = 1'b1;
    for (int c = 0; c < 4; c++) cycle("R11");
    chk("R11", int'(rawOut), 1, "raw held while deselected");
    chk("R11", int'(pinOut), 1, "pin idle while deselected");

    // R12: pin gating and polarity, raw unaffected by polarity
    chSel = 2'b10; outMode = 3'b101; cycle("R12");
    polarity = 1'b0; #1;
    chk("R12", int'(pinOut), 1, "pin = raw, polarity 0");
    polarity = 1'b1; #1;
    chk("R12", int'(pinOut), 0, "pin = ~raw, polarity 1");
    chk("R12", int'(rawOut), 1, "raw unaffected by polarity");
    chEnable = 1'b0; #1;
    chk("R12", int'(pinOut), 1, "disabled pin at polarity");
    cycle("R12");

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule